// File: doc/BRIEF.md
# Bunch Phase Record Ring Logger

This block turns the per-bunch averaged phase values of a storage ring into fixed-length records and writes them, one 16-bit word per cycle, into circular regions of an external memory. A turn strobe marks each revolution. After a set number of turns the block takes a snapshot of all bunch values and forms one record. The record holds a 32-bit serial number (two words), the mean of the bunch values, and then each bunch value in bunch order. Every data value is 12 bits wide, zero-extended to 16.

One record formatter feeds several independent capture channels, two by default. Each channel writes to its own region of the memory. Each channel has an arm bit, an auto-restart option, and a start code and a stop code that are compared against a stream of timing events. Manual start and stop pulses do the same job. When a channel stops, it latches the current timestamp. A stop that arrives while a record is being written lets that record finish, so a region never holds a partial record. Each region's write pointer wraps after a whole number of records, and a sticky flag shows that the first wrap has happened.

Top module: `phase_ring_logger`

## Requirements
- R1: After reset no channel writes, and `armed`, `running`, `wrapped` and `stop_ts` are all zero.
- R2: Record word 0 is bits 31:16 and word 1 is bits 15:0 of the record serial number. The serial number counts every record formed since reset, starting at 0, whether or not any channel captures the record.
- R3: Record word 2 is floor(sum of the NB bunch values / NB), zero-extended to 16 bits.
- R4: A record is formed on every TPR-th turn strobe. Its NB+3 words are presented on consecutive cycles starting one cycle after that strobe. Words 3..NB+2 are the 12-bit values of bunch 0..NB-1, sampled at the closing strobe, with the upper 4 bits zero.
- R5: A channel starts running on `man_start` or on an event whose code equals its start code, but only if it is armed and not already running. A start while unarmed is ignored.
- R6: Channel c writes word k of its region at address c*DEPTH_RECS*(NB+3) + k. The pointer advances by one per word written and returns to 0 after DEPTH_RECS*(NB+3) words. `wrapped` becomes 1 on the first return and stays set.
- R7: A running channel stops on `man_stop` or on an event matching its stop code. A record whose first word was written is still completed in full. No later record is written.
- R8: On a stop, `stop_ts` takes the value of `ts_in` in the stop cycle.
- R9: A stop clears `armed` when auto-restart is off, so a later start is ignored until the channel is re-armed. With auto-restart on, `armed` stays set and the next start resumes capture.
- R10: The controls, codes and pointers of one channel have no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| turn_strobe | input | 1 | One-cycle pulse per revolution |
| bunch_phase | input | NB*12 | Per-bunch averaged phases, bunch b at bits [12b+11:12b] |
| evt_valid | input | 1 | Timing event present this cycle |
| evt_code | input | 8 | Timing event code |
| start_code | input | NCH*8 | Per-channel start event code |
| stop_code | input | NCH*8 | Per-channel stop event code |
| man_start | input | NCH | Per-channel manual start pulse |
| man_stop | input | NCH | Per-channel manual stop pulse |
| arm_set | input | NCH | Per-channel arm pulse |
| auto_rst | input | NCH | Per-channel auto-restart enable |
| ts_in | input | 32 | Current timestamp |
| wr_en | output | NCH | Per-channel memory write strobe |
| wr_addr | output | NCH*AW | Per-channel memory word address |
| wr_data | output | 16 | Record word, shared by all channels |
| armed | output | NCH | Per-channel arm state |
| running | output | NCH | Per-channel capture state |
| wrapped | output | NCH | Per-channel sticky first-wrap flag |
| stop_ts | output | NCH*32 | Per-channel timestamp latched at the last stop |

## Verification
The bench stops both channels while a record is being written. A design that cut the record short would leave fewer words than expected in the scoreboard, and one that ignored the stop would write the next record unexpectedly. The region depth is two records, so the third record must land at the region base with `wrapped` set; an off-by-one in the wrap would shift every later address. After a stop, the non-restarting channel is sent its start code and must stay idle, while the auto-restart channel must resume. One record holds only full-scale values to probe the mean at its largest sum, and the serial number is checked on records that no channel captured, which exposes a counter that only advances on capture.

// File: rtl/phrec_pkg.sv
package phrec_pkg;
  localparam int WORD_W = 16;
  localparam int PH_W   = 12;
  localparam int HDR_W  = 3;
  localparam int CODE_W = 8;
  localparam int TS_W   = 32;
  localparam int CNT_W  = 32;

  function automatic int rec_words(input int nb);
    return nb + HDR_W;
  endfunction
endpackage

// File: rtl/phrec_mean.sv
module phrec_mean
  import phrec_pkg::*;
#(
  parameter int NB = 36
) (
  input  logic [NB*PH_W-1:0] vals,
  output logic [PH_W-1:0]    mean
);
  localparam int SW = PH_W + $clog2(NB + 1);

  logic [SW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int b = 0; b < NB; b++) begin
      sum = sum + SW'(vals[b*PH_W +: PH_W]);
    end
    mean = PH_W'(sum / SW'(NB));
  end
endmodule

// File: rtl/phrec_formatter.sv
module phrec_formatter
  import phrec_pkg::*;
#(
  parameter int NB  = 36,
  parameter int TPR = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               turn_strobe,
  input  logic [NB*PH_W-1:0] bunch_phase,
  output logic               emit_valid,
  output logic               emit_first,
  output logic               emit_last,
  output logic [WORD_W-1:0]  emit_word
);
  localparam int RW  = rec_words(NB);
  localparam int IW  = $clog2(RW + 1);
  localparam int TCW = $clog2(TPR + 1);

  logic [TCW-1:0]     tcnt_q, tcnt_d;
  logic [CNT_W-1:0]   serial_q, serial_d;
  logic [CNT_W-1:0]   tag_q, tag_d;
  logic               emit_q, emit_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [NB*PH_W-1:0] snap_q;
  logic               close_rec;
  logic [PH_W-1:0]    mean;

  phrec_mean #(.NB(NB)) u_mean (
    .vals (snap_q),
    .mean (mean)
  );

  assign close_rec = turn_strobe && (tcnt_q == TCW'(TPR - 1));

  // next state
  always_comb begin
    tcnt_d   = tcnt_q;
    serial_d = serial_q;
    tag_d    = tag_q;
    emit_d   = emit_q;
    idx_d    = idx_q;
    if (turn_strobe) begin
      tcnt_d = close_rec ? '0 : tcnt_q + 1'b1;
    end
    if (close_rec) begin
      tag_d    = serial_q;
      serial_d = serial_q + 1'b1;
      emit_d   = 1'b1;
      idx_d    = '0;
    end else if (emit_q) begin
      if (idx_q == IW'(RW - 1)) begin
        emit_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q   <= '0;
      serial_q <= '0;
      tag_q    <= '0;
      emit_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      tcnt_q   <= tcnt_d;
      serial_q <= serial_d;
      tag_q    <= tag_d;
      emit_q   <= emit_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (close_rec) begin
      snap_q <= bunch_phase;
    end
  end

  // word select
  always_comb begin
    emit_word = '0;
    if (idx_q == IW'(0)) begin
      emit_word = tag_q[CNT_W-1:WORD_W];
    end else if (idx_q == IW'(1)) begin
      emit_word = tag_q[WORD_W-1:0];
    end else if (idx_q == IW'(2)) begin
      emit_word = WORD_W'(mean);
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (idx_q == IW'(b + HDR_W)) begin
          emit_word = WORD_W'(snap_q[b*PH_W +: PH_W]);
        end
      end
    end
  end

  assign emit_valid = emit_q;
  assign emit_first = emit_q && (idx_q == '0);
  assign emit_last  = emit_q && (idx_q == IW'(RW - 1));

  // R4
  word_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_q && idx_q != IW'(RW - 1)) |=> (emit_q && idx_q == $past(idx_q) + 1'b1));

  // R2
  serial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_rec |=> (serial_q == tag_q + 1'b1));
endmodule

// File: rtl/phrec_channel.sv
module phrec_channel
  import phrec_pkg::*;
#(
  parameter int RW         = 39,
  parameter int DEPTH_RECS = 4,
  parameter int CH_IDX     = 0,
  parameter int AW         = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit_valid,
  input  logic              emit_first,
  input  logic              emit_last,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] stop_code,
  input  logic              man_start,
  input  logic              man_stop,
  input  logic              arm_set,
  input  logic              auto_rst,
  input  logic [TS_W-1:0]   ts_in,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              armed,
  output logic              running,
  output logic              wrapped,
  output logic [TS_W-1:0]   stop_ts
);
  localparam int DW   = DEPTH_RECS * RW;
  localparam int PW   = $clog2(DW);
  localparam int BASE = CH_IDX * DW;

  logic            armed_q, armed_d;
  logic            run_q, run_d;
  logic            inrec_q, inrec_d;
  logic            wrap_q, wrap_d;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic            start_hit, stop_hit, stop_now, at_end;

  assign start_hit = man_start || (evt_valid && evt_code == start_code);
  assign stop_hit  = man_stop  || (evt_valid && evt_code == stop_code);
  assign stop_now  = run_q && stop_hit;
  assign wr_en     = emit_valid && (emit_first ? run_q : inrec_q);
  assign at_end    = (ptr_q == PW'(DW - 1));

  // next state
  always_comb begin
    armed_d = armed_q;
    run_d   = run_q;
    inrec_d = inrec_q;
    wrap_d  = wrap_q;
    ptr_d   = ptr_q;
    ts_d    = ts_q;
    if (run_q) begin
      run_d = !stop_hit;
    end else if (armed_q && start_hit) begin
      run_d = 1'b1;
    end
    if (arm_set) begin
      armed_d = 1'b1;
    end else if (stop_now && !auto_rst) begin
      armed_d = 1'b0;
    end
    if (stop_now) begin
      ts_d = ts_in;
    end
    if (emit_valid && emit_last) begin
      inrec_d = 1'b0;
    end else if (emit_first) begin
      inrec_d = run_q;
    end
    if (wr_en) begin
      ptr_d = at_end ? '0 : ptr_q + 1'b1;
      if (at_end) begin
        wrap_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      inrec_q <= 1'b0;
      wrap_q  <= 1'b0;
      ptr_q   <= '0;
      ts_q    <= '0;
    end else begin
      armed_q <= armed_d;
      run_q   <= run_d;
      inrec_q <= inrec_d;
      wrap_q  <= wrap_d;
      ptr_q   <= ptr_d;
      ts_q    <= ts_d;
    end
  end

  assign wr_addr = AW'(BASE) + AW'(ptr_q);
  assign armed   = armed_q;
  assign running = run_q;
  assign wrapped = wrap_q;
  assign stop_ts = ts_q;

  // R5
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(armed_q));

  // R7
  record_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_valid && !emit_first && $past(wr_en)) |-> wr_en);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_end) |=> (wrap_q && ptr_q == '0));

  // R8
  stop_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (ts_q == $past(ts_in)));

  // R9
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_q) && !$past(auto_rst) && !$past(arm_set)) |-> !armed_q);
endmodule

// File: rtl/phase_ring_logger.sv
module phase_ring_logger
  import phrec_pkg::*;
#(
  parameter int NB         = 36,
  parameter int TPR        = 1024,
  parameter int DEPTH_RECS = 4,
  parameter int NCH        = 2,
  localparam int RW        = NB + HDR_W,
  localparam int AW        = $clog2(NCH * DEPTH_RECS * RW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  turn_strobe,
  input  logic [NB*PH_W-1:0]    bunch_phase,
  input  logic                  evt_valid,
  input  logic [CODE_W-1:0]     evt_code,
  input  logic [NCH*CODE_W-1:0] start_code,
  input  logic [NCH*CODE_W-1:0] stop_code,
  input  logic [NCH-1:0]        man_start,
  input  logic [NCH-1:0]        man_stop,
  input  logic [NCH-1:0]        arm_set,
  input  logic [NCH-1:0]        auto_rst,
  input  logic [TS_W-1:0]       ts_in,
  output logic [NCH-1:0]        wr_en,
  output logic [NCH*AW-1:0]     wr_addr,
  output logic [WORD_W-1:0]     wr_data,
  output logic [NCH-1:0]        armed,
  output logic [NCH-1:0]        running,
  output logic [NCH-1:0]        wrapped,
  output logic [NCH*TS_W-1:0]   stop_ts
);
  logic emit_valid, emit_first, emit_last;

  phrec_formatter #(.NB(NB), .TPR(TPR)) u_fmt (
    .clk         (clk),
    .rst_n       (rst_n),
    .turn_strobe (turn_strobe),
    .bunch_phase (bunch_phase),
    .emit_valid  (emit_valid),
    .emit_first  (emit_first),
    .emit_last   (emit_last),
    .emit_word   (wr_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    phrec_channel #(
      .RW         (RW),
      .DEPTH_RECS (DEPTH_RECS),
      .CH_IDX     (c),
      .AW         (AW)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .emit_valid (emit_valid),
      .emit_first (emit_first),
      .emit_last  (emit_last),
      .evt_valid  (evt_valid),
      .evt_code   (evt_code),
      .start_code (start_code[c*CODE_W +: CODE_W]),
      .stop_code  (stop_code[c*CODE_W +: CODE_W]),
      .man_start  (man_start[c]),
      .man_stop   (man_stop[c]),
      .arm_set    (arm_set[c]),
      .auto_rst   (auto_rst[c]),
      .ts_in      (ts_in),
      .wr_en      (wr_en[c]),
      .wr_addr    (wr_addr[c*AW +: AW]),
      .armed      (armed[c]),
      .running    (running[c]),
      .wrapped    (wrapped[c]),
      .stop_ts    (stop_ts[c*TS_W +: TS_W])
    );
  end
endmodule

// File: tb/phase_ring_logger_test.sv
module phase_ring_logger_test;
  localparam int CLK_NS = 10;
  localparam int NB     = 36;
  localparam int TPR    = 8;
  localparam int DR     = 2;
  localparam int NCH    = 2;
  localparam int RW     = NB + 3;
  localparam int DW     = DR * RW;
  localparam int AW     = $clog2(NCH * DW);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [15:0]   data;
    logic [7:0]    idx;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              turn_strobe = 1'b0;
  logic [NB*12-1:0]  bunch_phase = '0;
  logic              evt_valid = 1'b0;
  logic [7:0]        evt_code = '0;
  logic [15:0]       start_code = {8'h22, 8'h11};
  logic [15:0]       stop_code  = {8'h23, 8'h12};
  logic [1:0]        man_start = '0, man_stop = '0, arm_set = '0;
  logic [1:0]        auto_rst = 2'b10;
  logic [31:0]       ts_in = '0;
  logic [1:0]        wr_en, armed, running, wrapped;
  logic [NCH*AW-1:0] wr_addr;
  logic [15:0]       wr_data;
  logic [63:0]       stop_ts;

  phase_ring_logger #(.NB(NB), .TPR(TPR), .DEPTH_RECS(DR), .NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .turn_strobe(turn_strobe), .bunch_phase(bunch_phase),
    .evt_valid(evt_valid), .evt_code(evt_code), .start_code(start_code),
    .stop_code(stop_code), .man_start(man_start), .man_stop(man_stop),
    .arm_set(arm_set), .auto_rst(auto_rst), .ts_in(ts_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed), .running(running),
    .wrapped(wrapped), .stop_ts(stop_ts)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int   n_cmp = 0, n_bad = 0;
  int   rec_n = 0;
  bit   fin = 1'b0;
  bit   run_m [2];
  bit   arm_m [2];
  int   ptr_m [2];
  exp_t q0 [$];
  exp_t q1 [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      for (int c = 0; c < 2; c++) begin
        if (wr_en[c]) begin
          exp_t e;
          bit   have;
          have = (c == 0) ? (q0.size() > 0) : (q1.size() > 0);
          n_cmp++;
          if (!have) begin
            n_bad++;
            $display("FAIL R7: channel %0d unexpected write actual addr %0h data %0h expected none",
                     c, wr_addr[c*AW +: AW], wr_data);
          end else begin
            e = (c == 0) ? q0.pop_front() : q1.pop_front();
            if (wr_addr[c*AW +: AW] !== e.addr) begin
              n_bad++;
              $display("FAIL R6: channel %0d address actual %0h expected %0h",
                       c, wr_addr[c*AW +: AW], e.addr);
            end else if (wr_data !== e.data) begin
              n_bad++;
              $display("FAIL %s: channel %0d word %0d actual %0h expected %0h",
                       (e.idx < 2) ? "R2" : (e.idx == 2) ? "R3" : "R4",
                       c, e.idx, wr_data, e.data);
            end
          end
        end
      end
    end
  end

  function automatic logic [11:0] bval(input int r, input int b);
    if (r == 2) return 12'hFFF;
    return 12'((r * 53 + b * 97 + 5) % 4096);
  endfunction

  // driver: forms one record, pushing expected words for capturing channels
  task automatic do_record();
    int   sum = 0;
    exp_t e;
    for (int b = 0; b < NB; b++) begin
      bunch_phase[b*12 +: 12] = bval(rec_n, b);
      sum += int'(bval(rec_n, b));
    end
    for (int c = 0; c < 2; c++) begin
      if (run_m[c]) begin
        for (int w = 0; w < RW; w++) begin
          e.addr = AW'(c * DW + ptr_m[c]);
          e.idx  = 8'(w);
          if (w == 0) e.data = 16'(rec_n >>> 16);
          else if (w == 1) e.data = 16'(rec_n);
          else if (w == 2) e.data = 16'(sum / NB);
          else e.data = 16'(bval(rec_n, w - 3));
          if (c == 0) q0.push_back(e); else q1.push_back(e);
          ptr_m[c] = (ptr_m[c] + 1) % DW;
        end
      end
    end
    rec_n++;
    for (int t = 0; t < TPR; t++) begin
      @(negedge clk) turn_strobe = 1'b1;
      @(negedge clk) turn_strobe = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_evt(input logic [7:0] code);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_code  = code;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic model_start(input int c);
    if (arm_m[c] && !run_m[c]) run_m[c] = 1'b1;
  endtask

  task automatic model_stop(input int c);
    if (run_m[c]) begin
      run_m[c] = 1'b0;
      if (!auto_rst[c]) arm_m[c] = 1'b0;
    end
  endtask

  task automatic pulse(input int kind, input int c);
    @(negedge clk);
    case (kind)
      0: arm_set[c] = 1'b1;
      1: man_start[c] = 1'b1;
      default: man_stop[c] = 1'b1;
    endcase
    @(negedge clk);
    arm_set = '0; man_start = '0; man_stop = '0;
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      run_m[c] = 1'b0; arm_m[c] = 1'b0; ptr_m[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 armed", 32'(armed), 0);
    chk("R1 running", 32'(running), 0);
    chk("R1 wrapped", 32'(wrapped), 0);
    chk("R1 stop_ts", stop_ts[31:0] | stop_ts[63:32], 0);
    chk("R1 wr_en", 32'(wr_en), 0);

    // R5 start while unarmed is ignored
    pulse(1, 0);
    chk("R5 unarmed start", 32'(running), 0);
    do_record();  // record 0: nobody captures

    pulse(0, 0); arm_m[0] = 1'b1;
    pulse(0, 1); arm_m[1] = 1'b1;
    chk("R5 arm", 32'(armed), 32'b11);
    send_evt(8'h11); model_start(0);
    // R10 channel 1 unaffected by channel 0 start code
    chk("R5 R10 event start", 32'(running), 32'b01);
    pulse(1, 1); model_start(1);
    chk("R5 manual start", 32'(running), 32'b11);

    do_record();  // 1
    chk("R6 no wrap yet", 32'(wrapped), 0);
    do_record();  // 2 (full-scale values)
    do_record();  // 3 wraps to region base
    do_record();  // 4, stops land while it is written
    chk("R6 wrapped", 32'(wrapped), 32'b11);

    @(negedge clk) ts_in = 32'hCAFE_0001;
    send_evt(8'h12); model_stop(0);
    @(negedge clk) ts_in = 32'h0BAD_F00D;
    pulse(2, 1); model_stop(1);
    ts_in = 32'h1111_2222;
    chk("R7 running after stop", 32'(running), 0);
    chk("R9 arm after stop", 32'(armed), 32'b10);
    chk("R8 ts ch0", stop_ts[31:0], 32'hCAFE_0001);
    chk("R8 ts ch1", stop_ts[63:32], 32'h0BAD_F00D);

    do_record();  // 5: nothing
    send_evt(8'h11); model_start(0);
    chk("R9 no restart without arm", 32'(running[0]), 0);
    send_evt(8'h22); model_start(1);
    chk("R9 auto restart", 32'(running[1]), 1);
    do_record();  // 6: channel 1 only

    pulse(0, 0); arm_m[0] = 1'b1;
    pulse(1, 0); model_start(0);
    chk("R9 rearm start", 32'(running), 32'b11);
    do_record();  // 7: both
    repeat (50) @(negedge clk);

    chk("R7 leftover ch0", q0.size(), 0);
    chk("R7 leftover ch1", q1.size(), 0);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule